// File: doc/BRIEF.md
# I2S Serial Audio Transceiver

This block carries audio samples between a parallel sample interface and a four-wire serial audio link. The link has a continuous bit clock, a word-select line, one serial input and one serial output. Each bit takes one bit-clock period, and bits go most significant first. Word select low marks a left-channel word and high marks a right-channel word. The line changes one bit time before the first bit of each word, so the spacing between its transitions sets the word length.

The same core can act as clock master or as slave, chosen at run time. As master it divides the system clock to make the bit clock and drives word select itself. As slave it passes the external bit clock, word select and serial data through two-flop synchronisers and finds the edges in the system clock domain. A global enable gates the whole transceiver. The transmit and receive paths can be enabled separately, which gives full or half duplex operation. In mono mode one transmit sample fills both channel slots. The transmit side raises a completion flag each time it takes a new sample. The receive side raises one each time a right-channel word is complete. Each flag has its own interrupt enable.

Top module: `i2s_xcvr`

## Requirements
- R1: In master mode the bit clock `sck_out` alternates between high and low phases, each `half_div` system cycles long (a value of 0 counts as 1). It first goes high `half_div` clock edges after `enable` is seen high.
- R2: In master mode `ws_out` is 1 until the first falling edge of `sck_out`. It then toggles on falling edges number 1, WORD_W+1, 2*WORD_W+1, and so on. Value 0 means left and value 1 means right.
- R3: `sd_out` changes only on bit-clock falling edges. A word starts on the first falling edge after the rising edge at which a word-select change was sampled. It carries bits WORD_W-1 down to 0, one per bit clock.
- R4: In stereo mode every word start copies the transmit holding register (written by `tx_load`) into the shifter and sets `tx_flag`.
- R5: In mono mode a left word takes the holding register and sets `tx_flag`. The right word that follows resends the same sample and does not set `tx_flag`.
- R6: The receiver samples on rising bit-clock edges. At a rising edge where the sampled word select differs from its previous sample, the receiver ends the current word:
  - `rx_data` is loaded with the last WORD_W bits, with that edge's bit as the LSB.
  - `rx_chan` is loaded with the previous word-select value.
  - `rx_valid` pulses for one cycle.
  The first such boundary after enable produces no word.
- R7: `rx_flag` sets in the cycle after an `rx_valid` pulse with `rx_chan` = 1. Both flags stay set until their clear input is 1 in a cycle. If a set and a clear arrive in the same cycle, the set wins.
- R8: `irq_tx` and `irq_rx` are each the flag ANDed with its interrupt enable.
- R9: While `enable` is 0, the following hold from the next cycle: `sck_out`, `ws_out` and `sd_out` are 0, no `rx_valid` occurs and no flag sets. Framing restarts when `enable` returns.
- R10: With `tx_en` at 0, `sd_out` stays 0 and `tx_flag` never sets. With `rx_en` at 0, no `rx_valid` occurs and `rx_flag` never sets.
- R11: In slave mode `sck_out` and `ws_out` stay 0, and `sck_in`, `ws_in` and `sd_in` pass through two-flop synchronisers. `sd_out` updates three system cycles after an external falling edge, so the external half period must exceed three system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global transceiver enable |
| master | input | 1 | 1 = clock master, 0 = slave |
| mono | input | 1 | 1 = one sample sent on both channels |
| tx_en | input | 1 | Transmit path enable |
| rx_en | input | 1 | Receive path enable |
| half_div | input | DIV_W | Bit-clock half period in system cycles (master) |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| sd_in | input | 1 | Serial data in |
| sck_out | output | 1 | Bit clock driven in master mode |
| ws_out | output | 1 | Word select driven in master mode |
| sd_out | output | 1 | Serial data out |
| tx_data | input | WORD_W | Sample written to the holding register |
| tx_load | input | 1 | Write strobe for `tx_data` |
| rx_data | output | WORD_W | Last received word |
| rx_chan | output | 1 | Channel of `rx_data` (0 left, 1 right) |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` updates |
| irq_tx_en | input | 1 | Transmit interrupt enable |
| irq_rx_en | input | 1 | Receive interrupt enable |
| tx_flag_clr | input | 1 | Write-1 clear of `tx_flag` |
| rx_flag_clr | input | 1 | Write-1 clear of `rx_flag` |
| tx_flag | output | 1 | Transmit-complete flag |
| rx_flag | output | 1 | Receive-complete flag |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
The bench models the link behaviourally. It models the divider, the framing and the sample sequence itself, and compares the serial lines against that model on every system clock.

Faults show up at the ports quickly. A wrong divider count or word-select counter makes `sck_out` or `ws_out` disagree within one bit period. A framing or shifter fault corrupts `sd_out` within the first word. Through the loopback, the same fault also appears one word later as a wrong `rx_data` or `rx_chan`.

Flag faults show up at the end of a run. A lost mono copy or a wrong flag condition leaves the count of holding-register refills different from the count of word starts, and the bench checks that count after each run.

// File: rtl/i2s_xcvr_pkg.sv
// Shared types for the serial audio transceiver.
// Assumes: channel coding is fixed by the link (0 = left, 1 = right).
package i2s_xcvr_pkg;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2s_xcvr_clkgen.sv
// Master timing generator: divides the system clock into the bit clock
// and counts falling edges to drive word select.
// Assumes: run low holds it idle with the clock low and word select high,
// so the first falling edge after start switches word select to left.
module i2s_xcvr_clkgen #(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             ws,
    output logic             rise,
    output logic             fall
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0]    LAST_BIT = BW'(WORD_W - 1);
    localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;
    logic [BW-1:0]    bcnt_q;
    logic             sck_q;
    logic             ws_q;
    logic             term;

    // Half-period limit; a zero setting behaves as one.
    assign lim  = (half_div == '0) ? ONE : half_div;
    assign term = (cnt_q >= lim - ONE);
    assign rise = run & term & ~sck_q;
    assign fall = run & term & sck_q;
    assign sck  = sck_q;
    assign ws   = ws_q;

    // Divider, bit clock toggle and word-select counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q  <= '0;
            sck_q  <= 1'b0;
            ws_q   <= 1'b1;
            bcnt_q <= LAST_BIT;
        end else if (term) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
            if (sck_q) begin
                if (bcnt_q == LAST_BIT) begin
                    bcnt_q <= '0;
                    ws_q   <= ~ws_q;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R2
    ws_changes_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (ws_q != $past(ws_q))) |-> $past(fall));
endmodule

// File: rtl/i2s_xcvr_insync.sv
// Slave input conditioning: two-flop synchronisers on the external bit
// clock, word select and data, with bit-clock edge detection.
// Assumes: external half period is longer than three system cycles.
module i2s_xcvr_insync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic rise,
    output logic fall,
    output logic ws,
    output logic sd
);
    logic [2:0] sck_p;
    logic [1:0] ws_p;
    logic [1:0] sd_p;

    // Synchroniser chains; the clock chain has one extra stage for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            ws_p  <= '0;
            sd_p  <= '0;
        end else begin
            sck_p <= {sck_p[1:0], sck_in};
            ws_p  <= {ws_p[0], ws_in};
            sd_p  <= {sd_p[0], sd_in};
        end
    end

    assign rise = sck_p[1] & ~sck_p[2];
    assign fall = ~sck_p[1] & sck_p[2];
    assign ws   = ws_p[1];
    assign sd   = sd_p[1];

    // R11
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/i2s_xcvr_tx.sv
// Transmit path: holding register, mono copy and MSB-first shifter.
// Assumes: start is only asserted together with shift (a falling edge).
module i2s_xcvr_tx
    import i2s_xcvr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mono,
    input  logic              load,
    input  logic [WORD_W-1:0] ldata,
    input  logic              start,
    input  chan_e             start_ch,
    input  logic              shift,
    output logic              sd,
    output logic              took
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] copy_q;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] word;
    logic              sd_q;
    logic              fresh;

    // A fresh sample is taken in stereo, or on the left slot in mono.
    assign fresh = !mono || (start_ch == CH_LEFT);
    assign word  = fresh ? hold_q : copy_q;
    assign took  = run & start & fresh;
    assign sd    = sd_q;

    // Holding register written from the parallel side.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= ldata;
    end

    // Word load on start, otherwise shift one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sd_q   <= 1'b0;
            copy_q <= '0;
        end else if (!run) begin
            sh_q <= '0;
            sd_q <= 1'b0;
        end else if (start) begin
            sh_q <= {word[WORD_W-2:0], 1'b0};
            sd_q <= word[WORD_W-1];
            if (fresh) copy_q <= hold_q;
        end else if (shift) begin
            sd_q <= sh_q[WORD_W-1];
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    // R3
    sd_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (sd_q != $past(sd_q))) |-> $past(shift));
endmodule

// File: rtl/i2s_xcvr_rx.sv
// Receive path: shifts in on rising edges and presents a word at each
// word-select boundary after the first one.
// Assumes: boundary (chg) only occurs together with sample.
module i2s_xcvr_rx
    import i2s_xcvr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sample,
    input  logic              sd,
    input  logic              chg,
    input  chan_e             fin_ch,
    output logic [WORD_W-1:0] data,
    output chan_e             chan,
    output logic              valid
);
    logic [WORD_W-1:0] sh_q;
    logic              armed_q;

    // Shift, arm on the first boundary, present words on later ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            armed_q <= 1'b0;
            data    <= '0;
            chan    <= CH_LEFT;
            valid   <= 1'b0;
        end else if (!run) begin
            sh_q    <= '0;
            armed_q <= 1'b0;
            valid   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (sample) sh_q <= {sh_q[WORD_W-2:0], sd};
            if (chg) begin
                armed_q <= 1'b1;
                if (armed_q) begin
                    data  <= {sh_q[WORD_W-2:0], sd};
                    chan  <= fin_ch;
                    valid <= 1'b1;
                end
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/i2s_xcvr.sv
// Serial audio transceiver top: selects master or slave timing, frames
// words from word-select changes, and keeps the completion flags.
// Assumes: mode, mono and path enables change only while enable is low.
module i2s_xcvr
    import i2s_xcvr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master,
    input  logic              mono,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              sck_in,
    input  logic              ws_in,
    input  logic              sd_in,
    output logic              sck_out,
    output logic              ws_out,
    output logic              sd_out,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_chan,
    output logic              rx_valid,
    input  logic              irq_tx_en,
    input  logic              irq_rx_en,
    input  logic              tx_flag_clr,
    input  logic              rx_flag_clr,
    output logic              tx_flag,
    output logic              rx_flag,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic  m_run, m_sck, m_ws, m_rise, m_fall;
    logic  s_rise, s_fall, s_ws, s_sd;
    logic  rise_e, fall_e, ws_smp, sd_smp;
    logic  seen_q, ws_last_q, pend_q, chg, tx_start, tx_took;
    chan_e pend_ch_q, rx_chan_e;
    logic  tx_flag_q, rx_flag_q;

    assign m_run = enable & master;

    i2s_xcvr_clkgen #(.WORD_W(WORD_W), .DIV_W(DIV_W)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .run(m_run), .half_div(half_div),
        .sck(m_sck), .ws(m_ws), .rise(m_rise), .fall(m_fall)
    );

    i2s_xcvr_insync insync_i (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .rise(s_rise), .fall(s_fall), .ws(s_ws), .sd(s_sd)
    );

    // Event source selection between own timing and external timing.
    assign rise_e = master ? m_rise : s_rise;
    assign fall_e = master ? m_fall : s_fall;
    assign ws_smp = master ? m_ws   : s_ws;
    assign sd_smp = master ? sd_in  : s_sd;

    assign chg      = rise_e & seen_q & (ws_smp != ws_last_q);
    assign tx_start = fall_e & pend_q;

    // Framing: record word select at rising edges, arm a start on change.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            seen_q    <= 1'b0;
            ws_last_q <= 1'b0;
            pend_q    <= 1'b0;
            pend_ch_q <= CH_LEFT;
        end else if (rise_e) begin
            seen_q    <= 1'b1;
            ws_last_q <= ws_smp;
            if (chg) begin
                pend_q    <= 1'b1;
                pend_ch_q <= chan_e'(ws_smp);
            end
        end else if (fall_e) begin
            pend_q <= 1'b0;
        end
    end

    i2s_xcvr_tx #(.WORD_W(WORD_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .run(enable & tx_en), .mono(mono),
        .load(tx_load), .ldata(tx_data), .start(tx_start), .start_ch(pend_ch_q),
        .shift(fall_e), .sd(sd_out), .took(tx_took)
    );

    i2s_xcvr_rx #(.WORD_W(WORD_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .run(enable & rx_en), .sample(rise_e),
        .sd(sd_smp), .chg(chg), .fin_ch(chan_e'(ws_last_q)),
        .data(rx_data), .chan(rx_chan_e), .valid(rx_valid)
    );

    assign rx_chan = rx_chan_e;
    assign sck_out = m_run & m_sck;
    assign ws_out  = m_run & m_ws;

    // Completion flags: set has priority over the write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag_q <= 1'b0;
            rx_flag_q <= 1'b0;
        end else begin
            if (tx_took)                               tx_flag_q <= 1'b1;
            else if (tx_flag_clr)                      tx_flag_q <= 1'b0;
            if (rx_valid && rx_chan_e == CH_RIGHT)     rx_flag_q <= 1'b1;
            else if (rx_flag_clr)                      rx_flag_q <= 1'b0;
        end
    end

    assign tx_flag = tx_flag_q;
    assign rx_flag = rx_flag_q;
    assign irq_tx  = tx_flag_q & irq_tx_en;
    assign irq_rx  = rx_flag_q & irq_rx_en;

    // R7
    rx_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag_q && !rx_flag_clr) |=> rx_flag_q);
    // R10
    tx_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag_q) |-> $past(enable && tx_en));
    // R9
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sck_out && !sd_out));
endmodule

// File: tb/i2s_xcvr_tb_top.sv
// Bench: behavioural model of the serial link compared every system clock.
module i2s_xcvr_tb_top;
    localparam int CLK_P = 10;
    localparam int W     = 8;
    localparam int DW    = 8;
    localparam int D     = 2;
    localparam int H     = 5;

    logic clk = 1'b0;
    logic rst_n, enable, master, mono, tx_en, rx_en;
    logic [DW-1:0] half_div;
    logic sck_in, ws_in, sd_in, sd_drv;
    logic sck_out, ws_out, sd_out;
    logic [W-1:0] tx_data, rx_data;
    logic tx_load, rx_chan, rx_valid;
    logic irq_tx_en, irq_rx_en, tx_flag_clr, rx_flag_clr;
    logic tx_flag, rx_flag, irq_tx, irq_rx;

    int n_chk = 0;
    int n_err = 0;
    int ncyc  = 0;
    int k     = 0;
    int rxi   = 0;
    bit svc_rx = 1'b1;
    bit exp_rxf = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    assign sd_in = master ? sd_out : sd_drv;

    i2s_xcvr #(.WORD_W(W), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .mono(mono),
        .tx_en(tx_en), .rx_en(rx_en), .half_div(half_div),
        .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out),
        .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid),
        .irq_tx_en(irq_tx_en), .irq_rx_en(irq_rx_en),
        .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
        .tx_flag(tx_flag), .rx_flag(rx_flag), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] samp(input int i);
        return W'(i * 59 + 23);
    endfunction

    function automatic logic [W-1:0] rsamp(input int i);
        return W'(i * 101 + 200);
    endfunction

    function automatic logic [W-1:0] tword(input int wi);
        return mono ? samp(wi / 2) : samp(wi);
    endfunction

    function automatic logic ws_at(input int f);
        if (f == 0) return 1'b1;
        return 1'((((f - 1) / W) % 2));
    endfunction

    function automatic logic bit_at(input int f, input bit from_peer);
        logic [W-1:0] w;
        int wi;
        int b;
        if (f < 2) return 1'b0;
        wi = (f - 2) / W;
        b  = (f - 2) % W;
        w  = from_peer ? rsamp(wi) : tword(wi);
        return w[W-1-b];
    endfunction

    // One system cycle: drive the peer, compare with the model, act as software.
    task automatic step();
        int f;
        logic [W-1:0] expw;
        @(negedge clk);
        if (enable) ncyc++; else ncyc = 0;
        if (exp_rxf) chk(rx_flag === 1'b1, "R7 rx_flag after right word", rx_flag, 1);
        exp_rxf = rx_valid && rx_chan && rx_en && enable;
        if (enable && master) begin
            f = ncyc / (2 * D);
            chk(sck_out === 1'((ncyc / D) % 2), "R1 sck_out", sck_out, (ncyc / D) % 2);
            chk(ws_out === ws_at(f), "R2 ws_out", ws_out, ws_at(f));
            if (tx_en) chk(sd_out === bit_at(f, 0), mono ? "R5 sd_out mono" : "R3 sd_out", sd_out, bit_at(f, 0));
            else       chk(sd_out === 1'b0, "R10 sd_out with tx off", sd_out, 0);
        end
        if (enable && !master) begin
            f = ncyc / (2 * H);
            sck_in = 1'((ncyc / H) % 2);
            ws_in  = ws_at(f);
            sd_drv = bit_at(f, 1);
            chk(!sck_out && !ws_out, "R11 lines quiet in slave", {sck_out, ws_out}, 0);
            if (tx_en && (ncyc % (2 * H)) == 2 * H - 1)
                chk(sd_out === bit_at(f, 0), "R11 sd_out slave", sd_out, bit_at(f, 0));
        end
        if (!enable) begin
            chk({sck_out, ws_out, sd_out, rx_valid} === 4'b0, "R9 idle outputs",
                {sck_out, ws_out, sd_out, rx_valid}, 0);
        end
        if (rx_valid) begin
            if (!rx_en || !enable) begin
                chk(1'b0, "R10 rx_valid with rx off", 1, 0);
            end else begin
                expw = !master ? rsamp(rxi) : (tx_en ? tword(rxi) : '0);
                chk(rx_data === expw, mono ? "R5 rx word mono" : "R6 rx word", rx_data, expw);
                chk(rx_chan === 1'(rxi % 2), "R6 rx_chan", rx_chan, rxi % 2);
                rxi++;
            end
        end
        if (tx_flag && !(tx_en)) chk(1'b0, "R10 tx_flag with tx off", 1, 0);
        chk(irq_tx === (tx_flag & irq_tx_en), "R8 irq_tx", irq_tx, tx_flag & irq_tx_en);
        chk(irq_rx === (rx_flag & irq_rx_en), "R8 irq_rx", irq_rx, rx_flag & irq_rx_en);
        tx_load = 1'b0;
        tx_flag_clr = 1'b0;
        rx_flag_clr = 1'b0;
        if (tx_flag && tx_en) begin
            tx_flag_clr = 1'b1;
            k++;
            tx_data = samp(k);
            tx_load = 1'b1;
        end
        if (rx_flag && svc_rx) rx_flag_clr = 1'b1;
    endtask

    task automatic setup(input bit m, input bit mo, input bit t, input bit r);
        enable = 1'b0;
        step();
        step();
        tx_flag_clr = 1'b1;
        rx_flag_clr = 1'b1;
        master = m; mono = mo; tx_en = t; rx_en = r;
        sck_in = 1'b0; ws_in = 1'b0; sd_drv = 1'b0;
        k = 0; rxi = 0; exp_rxf = 1'b0;
        tx_data = samp(0);
        tx_load = 1'b1;
        step();
        tx_flag_clr = 1'b1;
        rx_flag_clr = 1'b1;
        step();
        enable = 1'b1;
    endtask

    initial begin
        int f;
        rst_n = 1'b0; enable = 1'b0; master = 1'b1; mono = 1'b0;
        tx_en = 1'b0; rx_en = 1'b0; half_div = DW'(D);
        sck_in = 1'b0; ws_in = 1'b0; sd_drv = 1'b0;
        tx_data = '0; tx_load = 1'b0; irq_tx_en = 1'b0; irq_rx_en = 1'b0;
        tx_flag_clr = 1'b0; rx_flag_clr = 1'b0;
        repeat (4) step();
        chk({tx_flag, rx_flag, rx_valid, sd_out, sck_out} === 5'b0, "R9 reset state",
            {tx_flag, rx_flag, rx_valid, sd_out, sck_out}, 0);
        rst_n = 1'b1;

        // Master stereo, full duplex with loopback.
        irq_tx_en = 1'b1; irq_rx_en = 1'b0;
        setup(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (200) step();
        f = ncyc / (2 * D);
        chk(k == (f - 2) / W + 1, "R4 stereo refills", k, (f - 2) / W + 1);
        chk(rxi >= 5, "R6 words received", rxi, 5);

        // Master mono.
        irq_tx_en = 1'b1; irq_rx_en = 1'b1;
        setup(1'b1, 1'b1, 1'b1, 1'b1);
        repeat (200) step();
        f = ncyc / (2 * D);
        chk(k == ((f - 2) / W) / 2 + 1, "R5 mono refills", k, ((f - 2) / W) / 2 + 1);

        // Slave stereo driven by the bench.
        setup(1'b0, 1'b0, 1'b1, 1'b1);
        repeat (500) step();
        chk(rxi >= 5, "R11 slave words received", rxi, 5);

        // Half duplex: transmit only.
        setup(1'b1, 1'b0, 1'b1, 1'b0);
        repeat (200) step();
        chk(rx_flag === 1'b0, "R10 rx_flag with rx off", rx_flag, 0);

        // Half duplex: receive only, flag left pending.
        svc_rx = 1'b0;
        setup(1'b1, 1'b0, 1'b0, 1'b1);
        repeat (200) step();
        chk(rx_flag === 1'b1, "R7 rx_flag set", rx_flag, 1);
        chk(irq_rx === 1'b1, "R8 irq_rx raised", irq_rx, 1);
        chk(tx_flag === 1'b0, "R10 tx_flag with tx off", tx_flag, 0);
        enable = 1'b0;
        repeat (30) step();
        chk(rx_flag === 1'b1, "R7 rx_flag held without clear", rx_flag, 1);
        rx_flag_clr = 1'b1;
        @(negedge clk);
        rx_flag_clr = 1'b0;
        chk(rx_flag === 1'b0, "R7 rx_flag cleared", rx_flag, 0);
        svc_rx = 1'b1;

        // Disabled: everything idle.
        repeat (40) step();
        chk({tx_flag, rx_flag} === 2'b0, "R9 no flags while disabled", {tx_flag, rx_flag}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule